// File: doc/BRIEF.md
# Two-Level Bank and Row Address Decoder

This block turns a binary word address into select lines for a banked memory. Decoding happens in two stages rather than in one flat decoder. The upper part of the address picks one bank. Each bank has its own small row decoder that looks only at the lower address bits, and that decoder is enabled only when its bank is the one picked. The result is a one-hot bank select and, for every bank, a one-hot row select. At most one storage location in the whole array is addressed at a time.

An access-enable input gates the whole decode. When it is low, every select line is quiet. The address width always equals the ceiling of log2 of the number of addressable words; for example, 1024 words need 10 address bits. The bank field can address more banks than are actually fitted. If the bank field points at an empty slot, nothing is selected and a range-error flag is raised instead. The decoded result is registered, so the selects appear one clock after the address and enable are presented. This lets the block drive wide, heavily loaded select lines from flops.

Top module: `hdec_two_level`

## Requirements
- R1: While reset is asserted, and after it is released until the first enabled access is registered, every bank select, every row select and the range-error flag are 0.
- R2: The address splits into a bank field (the upper ADDR_W-ROW_W bits) and a row field (the lower ROW_W bits). The defaults are ADDR_W=6, ROW_W=4 (16 rows per bank) and NUM_BANKS=3, so bank field values 0 to 2 are fitted and value 3 is an empty slot.
- R3: When enable is high and the bank field b is below NUM_BANKS, bit b of the bank select is the only bank select bit set.
- R4: In the same case, the row select bus has exactly one bit set. Its index is b*16 + r, where r is the row field, which equals the whole address value. For example, bank 0 with row 5 sets only bit 5.
- R5: When enable is low, all bank selects, all row selects and the range-error flag are 0, whatever the address.
- R6: When enable is high and the bank field is NUM_BANKS or above, no bank select and no row select is set, and the range-error flag is 1.
- R7: The bank select is one-hot or zero. The row select is one-hot or zero. A row select bit is set only inside the 16-bit slice of the bank that is selected.
- R8: Outputs change only on the rising clock edge. A new address or enable shows up one cycle later, and it holds unchanged between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; outputs update on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_en_i | input | 1 | Access enable; low suppresses all selects |
| addr_i | input | ADDR_W (6) | Word address: bank field above row field |
| bank_sel_o | output | NUM_BANKS (3) | One-hot bank select |
| row_sel_o | output | NUM_BANKS*2^ROW_W (48) | Per-bank one-hot row selects, bank b in bits b*16 upward |
| range_err_o | output | 1 | Enabled access to an unfitted bank slot |

## Verification
A wrong bank comparator or a mis-wired row slice shows up at the ports one clock after the offending address: either two select bits are set at once, or the set bit sits at an index other than the address value. A stuck register shows as selects that fail to clear after a disabled cycle or after reset. A range check with the wrong bound shows as the flag raised for bank 2, or missing for bank 3, again in the next cycle. Walking addresses that cover every bank, both row extremes, the empty slot and the disabled case exposes each of these within one cycle of the stimulus.

// File: rtl/hdec_pkg.sv
package hdec_pkg;

    // Outcome of one decode, kept in the registered state
    typedef enum logic [1:0] {
        DEC_IDLE = 2'd0,
        DEC_HIT  = 2'd1,
        DEC_MISS = 2'd2
    } dec_status_e;

endpackage

// File: rtl/hdec_bank_sel.sv
// First decode level: picks one fitted bank from the upper address bits.
module hdec_bank_sel #(
    parameter int BANK_W    = 2,
    parameter int NUM_BANKS = 3
) (
    input  logic                 en_i,
    input  logic [BANK_W-1:0]    bank_i,
    output logic [NUM_BANKS-1:0] sel_o,
    output logic                 miss_o
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign sel_o[b] = en_i && (bank_i == BANK_W'(b));
    end

    assign miss_o = en_i && (int'(bank_i) >= NUM_BANKS);

endmodule

// File: rtl/hdec_row_dec.sv
// Second decode level: one per bank, enabled only for the chosen bank.
module hdec_row_dec #(
    parameter int ROW_W = 4,
    localparam int ROWS = 1 << ROW_W
) (
    input  logic             en_i,
    input  logic [ROW_W-1:0] row_i,
    output logic [ROWS-1:0]  onehot_o
);

    always_comb begin
        onehot_o = '0;
        if (en_i) begin
            onehot_o[row_i] = 1'b1;
        end
    end

endmodule

// File: rtl/hdec_two_level.sv
module hdec_two_level
    import hdec_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int ROW_W     = 4,
    parameter int NUM_BANKS = 3
) (
    input  logic                                clk_i,
    input  logic                                rst_ni,
    input  logic                                acc_en_i,
    input  logic [ADDR_W-1:0]                   addr_i,
    output logic [NUM_BANKS-1:0]                bank_sel_o,
    output logic [NUM_BANKS*(1<<ROW_W)-1:0]     row_sel_o,
    output logic                                range_err_o
);

    localparam int BANK_W = ADDR_W - ROW_W;
    localparam int ROWS   = 1 << ROW_W;
    localparam int SEL_W  = NUM_BANKS * ROWS;

    typedef struct packed {
        logic [NUM_BANKS-1:0] bank;
        logic [SEL_W-1:0]     row;
        dec_status_e          status;
    } dec_state_t;

    logic [BANK_W-1:0]    bank_field;
    logic [ROW_W-1:0]     row_field;
    logic [NUM_BANKS-1:0] bank_hit;
    logic                 bank_miss;
    logic [SEL_W-1:0]     row_hit;

    dec_state_t state_d, state_q;

    assign bank_field = addr_i[ADDR_W-1:ROW_W];
    assign row_field  = addr_i[ROW_W-1:0];

    hdec_bank_sel #(
        .BANK_W    (BANK_W),
        .NUM_BANKS (NUM_BANKS)
    ) u_bank_sel (
        .en_i   (acc_en_i),
        .bank_i (bank_field),
        .sel_o  (bank_hit),
        .miss_o (bank_miss)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_rows
        hdec_row_dec #(
            .ROW_W (ROW_W)
        ) u_row_dec (
            .en_i     (bank_hit[b]),
            .row_i    (row_field),
            .onehot_o (row_hit[b*ROWS +: ROWS])
        );
    end

    always_comb begin
        state_d        = state_q;
        state_d.bank   = bank_hit;
        state_d.row    = row_hit;
        if (!acc_en_i) begin
            state_d.status = DEC_IDLE;
        end else if (bank_miss) begin
            state_d.status = DEC_MISS;
        end else begin
            state_d.status = DEC_HIT;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '{bank: '0, row: '0, status: DEC_IDLE};
        end else begin
            state_q <= state_d;
        end
    end

    assign bank_sel_o  = state_q.bank;
    assign row_sel_o   = state_q.row;
    assign range_err_o = (state_q.status == DEC_MISS);

endmodule

// File: rtl/hdec_two_level_chk.sv
module hdec_two_level_chk #(
    parameter int ADDR_W    = 6,
    parameter int ROW_W     = 4,
    parameter int NUM_BANKS = 3
) (
    input logic                            clk_i,
    input logic                            rst_ni,
    input logic                            acc_en_i,
    input logic [ADDR_W-1:0]               addr_i,
    input logic [NUM_BANKS-1:0]            bank_sel_o,
    input logic [NUM_BANKS*(1<<ROW_W)-1:0] row_sel_o,
    input logic                            range_err_o
);

    localparam int SEL_W = NUM_BANKS * (1 << ROW_W);

    logic in_range;
    assign in_range = int'(addr_i[ADDR_W-1:ROW_W]) < NUM_BANKS;

    AST_BANK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(bank_sel_o)); // R7

    AST_ROW_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(row_sel_o)); // R7

    AST_ROW_NEEDS_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|row_sel_o) == (|bank_sel_o)); // R7

    AST_BANK_PICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_en_i && in_range) |=>
        (bank_sel_o == (NUM_BANKS'(1) << $past(addr_i[ADDR_W-1:ROW_W])))); // R3

    AST_ROW_PICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_en_i && in_range) |=> (row_sel_o == (SEL_W'(1) << $past(addr_i)))); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !acc_en_i |=> (bank_sel_o == '0 && row_sel_o == '0 && !range_err_o)); // R5

    AST_MISS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_en_i && !in_range) |=> (range_err_o && bank_sel_o == '0 && row_sel_o == '0)); // R6

endmodule

bind hdec_two_level hdec_two_level_chk #(
    .ADDR_W    (ADDR_W),
    .ROW_W     (ROW_W),
    .NUM_BANKS (NUM_BANKS)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_en_i    (acc_en_i),
    .addr_i      (addr_i),
    .bank_sel_o  (bank_sel_o),
    .row_sel_o   (row_sel_o),
    .range_err_o (range_err_o)
);

// File: tb/hdec_two_level_tb_top.sv
module hdec_two_level_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 6;
    localparam int ROW_W      = 4;
    localparam int NUM_BANKS  = 3;
    localparam int SEL_W      = NUM_BANKS * 16;
    localparam int NVEC       = 12;

    // Vector: bit7 expected range error, bit6 enable, bits5:0 address
    localparam logic [7:0] VEC [NVEC] = '{
        8'h45, 8'h40, 8'h4F, 8'h50, 8'h5A, 8'h63,
        8'h6F, 8'hF0, 8'hFF, 8'h05, 8'h30, 8'h61
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 en = 1'b0;
    logic [ADDR_W-1:0]    addr = '0;
    logic [NUM_BANKS-1:0] bank_sel;
    logic [SEL_W-1:0]     row_sel;
    logic                 range_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdec_two_level #(
        .ADDR_W    (ADDR_W),
        .ROW_W     (ROW_W),
        .NUM_BANKS (NUM_BANKS)
    ) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .acc_en_i    (en),
        .addr_i      (addr),
        .bank_sel_o  (bank_sel),
        .row_sel_o   (row_sel),
        .range_err_o (range_err)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected outputs from the requirements (R3..R6)
    task automatic check_outputs(input logic e, input logic [ADDR_W-1:0] a, input string tag);
        logic [NUM_BANKS-1:0] eb;
        logic [SEL_W-1:0]     er;
        logic                 eo;
        int bank;
        bank = int'(a[5:4]);
        eb = '0;
        er = '0;
        eo = 1'b0;
        if (e && bank < NUM_BANKS) begin
            eb[bank] = 1'b1;
            er[int'(a)] = 1'b1;
        end else if (e) begin
            eo = 1'b1;
        end
        check({tag, " bank select R3"}, 64'(bank_sel), 64'(eb));
        check({tag, " row select R4"}, 64'(row_sel), 64'(er));
        check({tag, " range flag R6"}, 64'(range_err), 64'(eo));
    endtask

    task automatic apply(input logic e, input logic [ADDR_W-1:0] a);
        en   = e;
        addr = a;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("reset R1 bank", 64'(bank_sel), 64'd0);
        check("reset R1 row", 64'(row_sel), 64'd0);
        check("reset R1 flag", 64'(range_err), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("post-reset R1 row", 64'(row_sel), 64'd0);

        // Table walk: R2 field split, R3..R6
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][6], VEC[i][5:0]);
            check_outputs(VEC[i][6], VEC[i][5:0], "vector R2");
            check("vector flag column R6", 64'(range_err), 64'(VEC[i][7]));
        end

        // R4 worked example: bank 0 row 5 sets only bit 5
        apply(1'b1, 6'h05);
        check("row example R4", 64'(row_sel), 64'h20);

        // R7: slice of bank 1 only
        apply(1'b1, 6'h17);
        check("slice R7 bank0 empty", 64'(row_sel[15:0]), 64'd0);
        check("slice R7 bank2 empty", 64'(row_sel[47:32]), 64'd0);
        check("slice R7 bank1 bit", 64'(row_sel[31:16]), 64'h80);

        // R8: change inputs between edges, outputs hold until next edge
        en   = 1'b1;
        addr = 6'h2A;
        #1;
        check("hold R8 bank", 64'(bank_sel), 64'b010);
        @(posedge clk);
        @(negedge clk);
        check("update R8 bank", 64'(bank_sel), 64'b100);
        check("update R8 row", 64'(row_sel), 64'(1) << 42);

        // R5: enable drop clears a held hit
        apply(1'b0, 6'h2A);
        check("disable R5 row", 64'(row_sel), 64'd0);
        check("disable R5 bank", 64'(bank_sel), 64'd0);

        // R6 then R1: miss, then reset in mid-run clears flag
        apply(1'b1, 6'h3C);
        check("miss R6 flag", 64'(range_err), 64'd1);
        rst_n = 1'b0;
        #1;
        check("mid reset R1 flag", 64'(range_err), 64'd0);
        @(negedge clk);
        check("mid reset R1 bank", 64'(bank_sel), 64'd0);
        rst_n = 1'b1;
        en = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule